// File: doc/BRIEF.md
# Two-Axis Bit Array Memory

This block is a square array of N words, each N bits wide, that can be read or written along either axis through one N-bit bus. In column access, the address picks a bit position, and the bus carries that bit from every word at once. This suits bit-serial arithmetic, where every word is worked on in parallel. In row access, the address picks one word, and the bus carries the whole word. This is the path for loading and unloading records. A third, byte-interleaved access takes one bit position inside a byte from every byte of a group of eight words, so that matching byte fields of many records can be handled together.

Every write is qualified per lane by an N-bit mask, on every axis. A read is registered and delivered on the cycle after its strobe. The array is built from ordinary flops. N defaults to 32 for elaboration and is meant to be scaled up to 256 in a real build. N must be a power of two and at least 16.

Top module: `mda_memory`

## Requirements
- R1: Synchronous reset clears every cell and drives `rdata` to zero and `rd_valid` to 0. After reset, every read in every mode returns zeros until something is written.
- R2: With `mode` = 2'b00 (column access) and address k below N, a read returns `rdata[w]` = bit k of word w, for every w.
- R3: With `mode` = 2'b01 (row access) and address w below N, a read returns `rdata[b]` = bit b of word w, for every b.
- R4: With `mode` = 2'b10 (byte-interleaved access), the address splits into a group g (address bits above bit 2) and a bit-in-byte s (address bits 2:0). Lane i = v*(N/8)+j carries bit j*8+s of word g*8+v, for v in 0..7 and j in 0..N/8-1.
- R5: A write in modes 2'b00, 2'b01 or 2'b10 stores `wdata[i]` into the cell that lane i maps to under R2–R4, but only where `wmask[i]` is 1. All other cells keep their value.
- R6: `rd_valid` is 1 exactly on the cycle after a cycle with `rd_en` = 1. `rdata` changes only on such cycles and holds its value otherwise.
- R7: When a read and a write occur in the same cycle, the read returns the contents from before that write. The write still takes effect for later reads.
- R8: Mode 2'b11 is reserved. A write in this mode changes no cell, and a read in this mode returns zeros.
- R9: An address at or above N changes no cell on a write and returns zeros on a read, in every mode.
- R10: Data written along any axis is seen at the same cells by reads along every other axis, for any mix of modes, addresses and masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Access axis: 00 column, 01 row, 10 byte-interleaved, 11 reserved |
| addr | input | $clog2(N)+1 | Slice index; values of N or more are out of range |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | N | Write bus, one bit per lane |
| wmask | input | N | Write mask, 1 enables the lane |
| rdata | output | N | Registered read bus |
| rd_valid | output | 1 | High on the cycle after a read strobe |

## Verification
The array is first filled with distinct random words through row writes. It is then read back along all three axes, so a wrong lane-to-cell mapping in any one mode shows up as a permuted or shifted vector, not as a plain miscompare. Masked writes on each axis use sparse random masks, which separates a lane-mapping fault in the mask path from one in the data path. Reserved-mode writes, out-of-range writes and same-cycle read-write pairs are each followed by row reads, so a stray write appears in later data. A long random mix of modes, addresses, masks and strobes then checks cross-axis consistency against a behavioural model on every cycle.

// File: rtl/mda_pkg.sv
package mda_pkg;
  typedef enum logic [1:0] {
    MODE_COL  = 2'b00,
    MODE_ROW  = 2'b01,
    MODE_BYTE = 2'b10,
    MODE_RSV  = 2'b11
  } mda_mode_e;
endpackage

// File: rtl/mda_decode.sv
module mda_decode
  import mda_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = $clog2(N) + 1
) (
  input  logic [1:0]              mode,
  input  logic [AW-1:0]           addr,
  output logic                    sel_col,
  output logic                    sel_row,
  output logic                    sel_byte,
  output logic [$clog2(N)-1:0]    idx,
  output logic [$clog2(N)-4:0]    grp,
  output logic [2:0]              sub
);
  localparam int IW = $clog2(N);

  logic in_range;

  // The spare top address bit makes out-of-range indices representable
  assign in_range = (int'(addr) < N);
  assign idx      = addr[IW-1:0];
  assign grp      = addr[IW-1:3];
  assign sub      = addr[2:0];

  always_comb begin
    sel_col  = 1'b0;
    sel_row  = 1'b0;
    sel_byte = 1'b0;
    if (in_range) begin
      unique case (mda_mode_e'(mode))
        MODE_COL:  sel_col  = 1'b1;
        MODE_ROW:  sel_row  = 1'b1;
        MODE_BYTE: sel_byte = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/mda_array.sv
module mda_array #(
  parameter int N = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    sel_col,
  input  logic                    sel_row,
  input  logic                    sel_byte,
  input  logic [$clog2(N)-1:0]    idx,
  input  logic [$clog2(N)-4:0]    grp,
  input  logic [2:0]              sub,
  input  logic [N-1:0]            wdata,
  input  logic [N-1:0]            wmask,
  output logic [N*N-1:0]          cells
);
  localparam int IW  = $clog2(N);
  localparam int GW  = IW - 3;
  localparam int BPW = N / 8;

  // Cell (w,b) lives at cells[w*N+b]; each cell has fixed lane numbers per axis
  for (genvar w = 0; w < N; w++) begin : g_word
    for (genvar b = 0; b < N; b++) begin : g_bit
      localparam int LANE_BYTE = (w % 8) * BPW + (b / 8);

      logic hit;
      logic lane_d;
      logic lane_m;

      always_comb begin
        hit = (sel_col  && (idx == IW'(b))) ||
              (sel_row  && (idx == IW'(w))) ||
              (sel_byte && (grp == GW'(w / 8)) && (sub == 3'(b % 8)));
        if (sel_col) begin
          lane_d = wdata[w];
          lane_m = wmask[w];
        end else if (sel_row) begin
          lane_d = wdata[b];
          lane_m = wmask[b];
        end else begin
          lane_d = wdata[LANE_BYTE];
          lane_m = wmask[LANE_BYTE];
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          cells[w*N+b] <= 1'b0;
        end else if (wr_en && hit && lane_m) begin
          cells[w*N+b] <= lane_d;
        end
      end
    end
  end
endmodule

// File: rtl/mda_read_mux.sv
module mda_read_mux #(
  parameter int N = 32
) (
  input  logic [N*N-1:0]          cells,
  input  logic                    sel_col,
  input  logic                    sel_row,
  input  logic                    sel_byte,
  input  logic [$clog2(N)-1:0]    idx,
  input  logic [$clog2(N)-4:0]    grp,
  input  logic [2:0]              sub,
  output logic [N-1:0]            rd_vec
);
  localparam int BPW = N / 8;

  always_comb begin
    rd_vec = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_col) begin
        rd_vec[i] = cells[i*N + int'(idx)];
      end else if (sel_row) begin
        rd_vec[i] = cells[int'(idx)*N + i];
      end else if (sel_byte) begin
        rd_vec[i] = cells[(int'(grp)*8 + i/BPW)*N + (i%BPW)*8 + int'(sub)];
      end
    end
  end
endmodule

// File: rtl/mda_memory.sv
module mda_memory #(
  parameter int N = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               mode,
  input  logic [$clog2(N):0]       addr,
  input  logic                     rd_en,
  input  logic                     wr_en,
  input  logic [N-1:0]             wdata,
  input  logic [N-1:0]             wmask,
  output logic [N-1:0]             rdata,
  output logic                     rd_valid
);
  localparam int IW = $clog2(N);
  localparam int AW = IW + 1;
  localparam int GW = IW - 3;

  logic              sel_col;
  logic              sel_row;
  logic              sel_byte;
  logic [IW-1:0]     idx;
  logic [GW-1:0]     grp;
  logic [2:0]        sub;
  logic [N*N-1:0]    cells;
  logic [N-1:0]      rd_vec;

  mda_decode #(.N(N), .AW(AW)) u_decode (
    .mode     (mode),
    .addr     (addr),
    .sel_col  (sel_col),
    .sel_row  (sel_row),
    .sel_byte (sel_byte),
    .idx      (idx),
    .grp      (grp),
    .sub      (sub)
  );

  mda_array #(.N(N)) u_array (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .sel_col  (sel_col),
    .sel_row  (sel_row),
    .sel_byte (sel_byte),
    .idx      (idx),
    .grp      (grp),
    .sub      (sub),
    .wdata    (wdata),
    .wmask    (wmask),
    .cells    (cells)
  );

  mda_read_mux #(.N(N)) u_rmux (
    .cells    (cells),
    .sel_col  (sel_col),
    .sel_row  (sel_row),
    .sel_byte (sel_byte),
    .idx      (idx),
    .grp      (grp),
    .sub      (sub),
    .rd_vec   (rd_vec)
  );

  // Read samples the array before this edge's write lands: old data on collision
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rdata <= rd_vec;
      end
    end
  end
endmodule

// File: rtl/mda_memory_chk.sv
module mda_memory_chk #(
  parameter int N = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           mode,
  input logic [$clog2(N):0]   addr,
  input logic                 rd_en,
  input logic                 wr_en,
  input logic [N-1:0]         wdata,
  input logic [N-1:0]         wmask,
  input logic [N-1:0]         rdata,
  input logic                 rd_valid
);
  // R1: the cycle after reset shows a cleared output
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (rdata == '0 && !rd_valid));

  // R6: valid follows the read strobe by one cycle
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  a_r6_hold_data: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R8: reserved mode reads as zero
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mode == 2'b11) |=> rdata == '0);

  // R9: out-of-range address reads as zero
  a_r9_oor_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(addr) >= N) |=> rdata == '0);
endmodule

bind mda_memory mda_memory_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .addr     (addr),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .wdata    (wdata),
  .wmask    (wmask),
  .rdata    (rdata),
  .rd_valid (rd_valid)
);

// File: tb/mda_memory_tb.sv
`timescale 1ns/1ps
module mda_memory_tb;
  localparam int N   = 32;
  localparam int AW  = $clog2(N) + 1;
  localparam int BPW = N / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'b00;
  logic [AW-1:0] addr = '0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  wmask = '0;
  logic [N-1:0]  rdata;
  logic          rd_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [N-1:0] model [N];
  logic [N-1:0] exp_rdata = '0;
  logic         exp_valid = 1'b0;

  always #5 clk = ~clk;

  mda_memory #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .wmask(wmask), .rdata(rdata),
    .rd_valid(rd_valid)
  );

  function automatic logic [N-1:0] model_read(logic [1:0] m, int a);
    logic [N-1:0] r = '0;
    if (a >= N || m == 2'b11) return r;
    case (m)
      2'b00: for (int w = 0; w < N; w++) r[w] = model[w][a];
      2'b01: r = model[a];
      default: begin
        for (int v = 0; v < 8; v++)
          for (int j = 0; j < BPW; j++)
            r[v*BPW + j] = model[(a/8)*8 + v][j*8 + (a%8)];
      end
    endcase
    return r;
  endfunction

  task automatic model_write(logic [1:0] m, int a, logic [N-1:0] d, logic [N-1:0] k);
    if (a >= N || m == 2'b11) return;
    case (m)
      2'b00: for (int w = 0; w < N; w++) if (k[w]) model[w][a] = d[w];
      2'b01: for (int b = 0; b < N; b++) if (k[b]) model[a][b] = d[b];
      default: begin
        for (int v = 0; v < 8; v++)
          for (int j = 0; j < BPW; j++)
            if (k[v*BPW + j]) model[(a/8)*8 + v][j*8 + (a%8)] = d[v*BPW + j];
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < N; w++) model[w] = '0;
      exp_rdata = '0;
      exp_valid = 1'b0;
    end else begin
      exp_valid = rd_en;
      if (rd_en) exp_rdata = model_read(mode, int'(addr));
      if (wr_en) model_write(mode, int'(addr), wdata, wmask);
    end
  end

  function automatic logic [N-1:0] rvec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = 1'($urandom);
    return v;
  endfunction

  task automatic compare(string req);
    checks++;
    if (rdata !== exp_rdata || rd_valid !== exp_valid) begin
      errors++;
      $display("FAIL %s: rdata=%h valid=%b expected rdata=%h valid=%b",
               req, rdata, rd_valid, exp_rdata, exp_valid);
    end
  endtask

  // Drive one cycle at the falling edge, check after the next rising edge
  task automatic op(logic [1:0] m, int a, bit rd, bit wr,
                    logic [N-1:0] d, logic [N-1:0] k, string req);
    mode  = m;
    addr  = AW'(a);
    rd_en = rd;
    wr_en = wr;
    wdata = d;
    wmask = k;
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle(string req);
    op(2'b00, 0, 1'b0, 1'b0, '0, '0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle("R1");
    for (int a = 0; a < N; a += 5) op(2'b00, a, 1'b1, 1'b0, '0, '0, "R1");
    op(2'b10, 9, 1'b1, 1'b0, '0, '0, "R1");

    // Fill through row writes, then read along every axis
    for (int w = 0; w < N; w++) op(2'b01, w, 1'b0, 1'b1, rvec(), '1, "R5");
    for (int w = 0; w < N; w++) op(2'b01, w, 1'b1, 1'b0, '0, '0, "R3");
    for (int b = 0; b < N; b++) op(2'b00, b, 1'b1, 1'b0, '0, '0, "R2");
    for (int a = 0; a < N; a++) op(2'b10, a, 1'b1, 1'b0, '0, '0, "R4");

    // Hold behaviour with no read strobe
    op(2'b01, 3, 1'b1, 1'b0, '0, '0, "R6");
    for (int i = 0; i < 4; i++) idle("R6");

    // Masked writes on each axis, each followed by row readback
    for (int m = 0; m < 3; m++) begin
      for (int i = 0; i < 6; i++)
        op(2'(m), int'($urandom % N), 1'b0, 1'b1, rvec(), rvec() & rvec(), "R5");
      for (int w = 0; w < N; w++) op(2'b01, w, 1'b1, 1'b0, '0, '0, "R5");
    end

    // Read and write on the same slice in one cycle
    op(2'b01, 7, 1'b1, 1'b1, rvec(), '1, "R7");
    op(2'b01, 7, 1'b1, 1'b0, '0, '0, "R7");
    op(2'b00, 12, 1'b1, 1'b1, rvec(), rvec(), "R7");
    op(2'b00, 12, 1'b1, 1'b0, '0, '0, "R7");
    op(2'b10, 20, 1'b1, 1'b1, rvec(), '1, "R7");
    op(2'b10, 20, 1'b1, 1'b0, '0, '0, "R7");

    // Reserved mode
    for (int a = 0; a < N; a += 3) op(2'b11, a, 1'b0, 1'b1, '1, '1, "R8");
    op(2'b11, 4, 1'b1, 1'b0, '0, '0, "R8");
    for (int w = 0; w < N; w++) op(2'b01, w, 1'b1, 1'b0, '0, '0, "R8");

    // Out-of-range addresses
    for (int m = 0; m < 3; m++) begin
      op(2'(m), N, 1'b0, 1'b1, '1, '1, "R9");
      op(2'(m), 2*N - 1, 1'b0, 1'b1, '0, '1, "R9");
      op(2'(m), N + 1, 1'b1, 1'b0, '0, '0, "R9");
    end
    for (int w = 0; w < N; w++) op(2'b01, w, 1'b1, 1'b0, '0, '0, "R9");

    // Random mix across axes
    for (int i = 0; i < 1500; i++)
      op(2'($urandom), int'($urandom % (N + 4)), 1'($urandom), 1'($urandom),
         rvec(), rvec(), "R10");

    // Reset in mid-run clears the array
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle("R1");
    for (int w = 0; w < N; w += 4) op(2'b01, w, 1'b1, 1'b0, '0, '0, "R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule